// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches six external interrupt pins and turns activity on them into one prioritized interrupt request for a CPU core. Each pin passes through a two-flop synchronizer. A 2-bit trigger code per pin selects how activity is detected: active-low level, active-high level, falling edge or rising edge. A detected event latches a per-channel request flag. Software clears a flag by writing 0 to it. A per-channel enable and a 3-bit priority level decide whether the flag reaches the core and how urgently.

Software reaches the block through a simple register bus. Each transfer is a byte or a halfword, reads are combinational, and writes take effect on the next rising clock edge. The trigger codes share one 16-bit mode register at 0xFCF8. Channel n owns two adjacent bytes: a flag byte at 0xFC48+2n and a control byte at 0xFC49+2n. A halfword access at 0xFC48+2n covers both bytes, with the flag byte on data bits 7:0. A byte access always uses data bits 7:0.

The winning channel and its level are presented continuously on the interrupt output. A one-cycle acknowledge from the core retires an edge-triggered request.

The recommended setup order is: write the trigger code, clear any stale flag, then write the level and set the enable.

Top module: `pinIrqCtl`

## Requirements
- R1: After reset every trigger code is 00, every flag and control byte reads 0, and irqReq is 0.
- R2: In the mode register, pin n's trigger code occupies bits [2n+1:2n]. Bits 15:12 read 0 whatever was written, and a byte write to 0xFCF9 changes only bits 15:8.
- R3: With trigger code 10, a falling edge on the pin sets that channel's flag (flag-byte bit 0) on the third rising clock edge after the pin changes. A rising edge does not set it.
- R4: With trigger code 11, a rising edge on the pin sets the flag with the same latency. A falling edge does not set it.
- R5: With trigger code 00, the flag is set while the pin is low. A write of 0 to the flag while the pin stays low leaves it set. Once the pin is high, the same write clears it.
- R6: With trigger code 01, the flag is set while the pin is high, and the same clearing rule applies while the pin stays high.
- R7: Writing 0 to flag-byte bit 0 clears the flag on the next edge. Writing 1 never sets it, and the other bits of the flag byte read 0.
- R8: The control byte holds the level in bits 6:4 and the enable in bit 0, and its other bits read 0. A halfword write updates the flag byte and the control byte together.
- R9: A channel requests the core only when its flag and enable are both 1 and its level is not 7. If no channel qualifies, irqReq is 0.
- R10: Among requesting channels, irqLevel and irqChan show the one with the lowest level number. Equal levels go to the lower channel index.
- R11: An irqAck pulse while irqReq is 1 clears the flag of the presented channel if that channel uses trigger code 10 or 11. A presented channel with code 00 or 01 keeps its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 16 | Byte address of the register access |
| busWr | input | 1 | Write strobe for the current access |
| busHalf | input | 1 | 1 = halfword access, 0 = byte access |
| busWdata | input | 16 | Write data; byte writes use bits 7:0 |
| busRdata | output | 16 | Combinational read data; byte reads return the byte in bits 7:0 |
| pinIn | input | 6 | Asynchronous external interrupt pins |
| irqAck | input | 1 | One-cycle acknowledge from the core |
| irqReq | output | 1 | A qualifying request is present |
| irqLevel | output | 3 | Level of the presented request |
| irqChan | output | 3 | Channel index of the presented request |

## Verification
The bench targets the collision between a software clear and a level pin that is still asserted. A design that let the clear win would drop a request whose source is still active. It also drives opposite-polarity edges into edge-mode channels, which exposes an inverted or swapped trigger decode as a spurious or missing flag. Equal-level contention and a level-7 channel test the arbiter: a wrong tie-break, or a comparator that lets a masked level through, presents the wrong channel. The acknowledge is applied to both an edge channel and a level channel that has gone quiet, so a design that cleared on every acknowledge would lose the latched level event.

// File: rtl/pinIrqPkg.sv
package pinIrqPkg;
  // Width of a channel index; supports up to eight pins.
  localparam int CH_SEL_W = 3;

  // Trigger codes per pin.
  localparam logic [1:0] TRIG_LOW  = 2'b00;
  localparam logic [1:0] TRIG_HIGH = 2'b01;
  localparam logic [1:0] TRIG_FALL = 2'b10;
  localparam logic [1:0] TRIG_RISE = 2'b11;

  // Strobes handed from bus control to the datapath.
  typedef struct packed {
    logic                modeLoWr;
    logic                modeHiWr;
    logic                chLoWr;
    logic                chHiWr;
    logic [CH_SEL_W-1:0] chSel;
    logic [7:0]          loByte;
    logic [7:0]          hiByte;
  } wrStrobeT;
endpackage

// File: rtl/pinIrqCtrl.sv
module pinIrqCtrl
  import pinIrqPkg::*;
#(
  parameter int          NUM_CH    = 6,
  parameter int          LVL_W     = 3,
  parameter logic [15:0] MODE_ADDR = 16'hFCF8,
  parameter logic [15:0] CH_BASE   = 16'hFC48
) (
  input  logic [15:0]                   busAddr,
  input  logic                          busWr,
  input  logic                          busHalf,
  input  logic [15:0]                   busWdata,
  output logic [15:0]                   busRdata,
  input  logic [15:0]                   modeVal,
  input  logic [NUM_CH-1:0]             irVec,
  input  logic [NUM_CH-1:0]             ieVec,
  input  logic [NUM_CH-1:0][LVL_W-1:0]  lvlVec,
  output wrStrobeT                      strb
);
  localparam logic [15:0] CH_END = CH_BASE + 16'(2 * NUM_CH);

  logic                isMode;
  logic                isChan;
  logic [15:0]         chOffset;
  logic [CH_SEL_W-1:0] chIdx;
  logic                wantLo;
  logic                wantHi;
  logic [7:0]          loRd;
  logic [7:0]          hiRd;

  always_comb begin
    isMode   = (busAddr[15:1] == MODE_ADDR[15:1]);
    isChan   = (busAddr >= CH_BASE) && (busAddr < CH_END);
    chOffset = busAddr - CH_BASE;
    chIdx    = chOffset[CH_SEL_W:1];
    // A halfword touches both bytes of the pair; a byte access touches one.
    wantLo   = busHalf || !busAddr[0];
    wantHi   = busHalf || busAddr[0];
  end

  // Write strobes.
  always_comb begin
    strb          = '0;
    strb.chSel    = chIdx;
    strb.loByte   = busWdata[7:0];
    strb.hiByte   = busHalf ? busWdata[15:8] : busWdata[7:0];
    strb.modeLoWr = busWr && isMode && wantLo;
    strb.modeHiWr = busWr && isMode && wantHi;
    strb.chLoWr   = busWr && isChan && wantLo;
    strb.chHiWr   = busWr && isChan && wantHi;
  end

  // Read path.
  always_comb begin
    loRd = 8'h00;
    hiRd = 8'h00;
    if (isMode) begin
      loRd = modeVal[7:0];
      hiRd = modeVal[15:8];
    end else if (isChan) begin
      loRd = {7'b0, irVec[chIdx]};
      hiRd = 8'({lvlVec[chIdx], 4'b0000}) | {7'b0, ieVec[chIdx]};
    end
    if (busHalf) busRdata = {hiRd, loRd};
    else         busRdata = {8'h00, busAddr[0] ? hiRd : loRd};
  end
endmodule

// File: rtl/pinIrqDatapath.sv
module pinIrqDatapath
  import pinIrqPkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             pinIn,
  input  logic                          irqAck,
  input  wrStrobeT                      strb,
  output logic [15:0]                   modeVal,
  output logic [NUM_CH-1:0]             irVec,
  output logic [NUM_CH-1:0]             ieVec,
  output logic [NUM_CH-1:0][LVL_W-1:0]  lvlVec,
  output logic                          irqReq,
  output logic [LVL_W-1:0]              irqLevel,
  output logic [CH_SEL_W-1:0]           irqChan
);
  localparam int MODE_W = 2 * NUM_CH;

  logic [SYNC_STAGES-1:0][NUM_CH-1:0] syncReg;
  logic [NUM_CH-1:0] curPin;
  logic [NUM_CH-1:0] prevPin;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] ackClr;
  logic [MODE_W-1:0] modeReg;

  // Synchronizer chain; idles high so level-low channels stay quiet in reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncReg[0] <= '1;
    else       syncReg[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncReg[s] <= '1;
      else       syncReg[s] <= syncReg[s-1];
    end
  end

  assign curPin = syncReg[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevPin <= '1;
    else       prevPin <= curPin;
  end

  // Mode register bits, one byte lane each.
  for (genvar b = 0; b < MODE_W; b++) begin : g_mode
    if (b < 8) begin : g_lo
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              modeReg[b] <= 1'b0;
        else if (strb.modeLoWr) modeReg[b] <= strb.loByte[b];
      end
    end else begin : g_hi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              modeReg[b] <= 1'b0;
        else if (strb.modeHiWr) modeReg[b] <= strb.hiByte[b-8];
      end
    end
  end

  assign modeVal = 16'(modeReg);

  // Per-channel detection, flag, enable and level.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [1:0] trig;
    logic       selMe;

    assign trig  = modeReg[2*c+1 -: 2];
    assign selMe = (strb.chSel == CH_SEL_W'(c));

    always_comb begin
      unique case (trig)
        TRIG_LOW:  hit[c] = !curPin[c];
        TRIG_HIGH: hit[c] = curPin[c];
        TRIG_FALL: hit[c] = prevPin[c] && !curPin[c];
        default:   hit[c] = !prevPin[c] && curPin[c];
      endcase
    end

    // Only edge-triggered channels (code 1x) retire on acknowledge.
    assign ackClr[c] = irqAck && irqReq && (irqChan == CH_SEL_W'(c)) && trig[1];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        irVec[c] <= 1'b0;
      else if (hit[c])
        irVec[c] <= 1'b1;
      else if ((strb.chLoWr && selMe && !strb.loByte[0]) || ackClr[c])
        irVec[c] <= 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ieVec[c]  <= 1'b0;
        lvlVec[c] <= '0;
      end else if (strb.chHiWr && selMe) begin
        ieVec[c]  <= strb.hiByte[0];
        lvlVec[c] <= strb.hiByte[4 +: LVL_W];
      end
    end
  end

  // Arbiter: strict less-than keeps the lower index on ties and
  // never lets the all-ones (masked) level win.
  always_comb begin
    irqReq   = 1'b0;
    irqLevel = '1;
    irqChan  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (irVec[i] && ieVec[i] && (lvlVec[i] < irqLevel)) begin
        irqReq   = 1'b1;
        irqLevel = lvlVec[i];
        irqChan  = CH_SEL_W'(i);
      end
    end
  end
endmodule

// File: rtl/pinIrqCtl.sv
module pinIrqCtl
  import pinIrqPkg::*;
#(
  parameter int          NUM_CH      = 6,
  parameter int          LVL_W       = 3,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] MODE_ADDR   = 16'hFCF8,
  parameter logic [15:0] CH_BASE     = 16'hFC48
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [15:0]         busAddr,
  input  logic                busWr,
  input  logic                busHalf,
  input  logic [15:0]         busWdata,
  output logic [15:0]         busRdata,
  input  logic [NUM_CH-1:0]   pinIn,
  input  logic                irqAck,
  output logic                irqReq,
  output logic [LVL_W-1:0]    irqLevel,
  output logic [CH_SEL_W-1:0] irqChan
);
  wrStrobeT                      strb;
  logic [15:0]                   modeVal;
  logic [NUM_CH-1:0]             irVec;
  logic [NUM_CH-1:0]             ieVec;
  logic [NUM_CH-1:0][LVL_W-1:0]  lvlVec;

  pinIrqCtrl #(
    .NUM_CH(NUM_CH), .LVL_W(LVL_W), .MODE_ADDR(MODE_ADDR), .CH_BASE(CH_BASE)
  ) ctrlI (
    .busAddr(busAddr), .busWr(busWr), .busHalf(busHalf), .busWdata(busWdata),
    .busRdata(busRdata), .modeVal(modeVal), .irVec(irVec), .ieVec(ieVec),
    .lvlVec(lvlVec), .strb(strb)
  );

  pinIrqDatapath #(
    .NUM_CH(NUM_CH), .LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES)
  ) dpI (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .irqAck(irqAck), .strb(strb),
    .modeVal(modeVal), .irVec(irVec), .ieVec(ieVec), .lvlVec(lvlVec),
    .irqReq(irqReq), .irqLevel(irqLevel), .irqChan(irqChan)
  );
endmodule

// File: rtl/pinIrqChk.sv
module pinIrqChk
  import pinIrqPkg::*;
#(
  parameter int          NUM_CH    = 6,
  parameter int          LVL_W     = 3,
  parameter logic [15:0] MODE_ADDR = 16'hFCF8,
  parameter logic [15:0] CH_BASE   = 16'hFC48
) (
  input logic                clk,
  input logic                rstN,
  input logic [15:0]         busAddr,
  input logic                busHalf,
  input logic [15:0]         busRdata,
  input logic                irqReq,
  input logic [LVL_W-1:0]    irqLevel,
  input logic [CH_SEL_W-1:0] irqChan
);
  localparam logic [15:0] CH_END = CH_BASE + 16'(2 * NUM_CH);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !irqReq);

  // R9
  masked_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqLevel != '1));

  // R10
  chan_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ({1'b0, irqChan} < (CH_SEL_W+1)'(NUM_CH)));

  // R2
  mode_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busHalf && busAddr == MODE_ADDR) |-> ((busRdata >> (2 * NUM_CH)) == 16'h0));

  // R8
  ctl_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busHalf && busAddr[0] && busAddr >= CH_BASE && busAddr < CH_END)
      |-> (busRdata[15:7] == 9'h0 && busRdata[3:1] == 3'h0));
endmodule

bind pinIrqCtl pinIrqChk #(
  .NUM_CH(NUM_CH), .LVL_W(LVL_W), .MODE_ADDR(MODE_ADDR), .CH_BASE(CH_BASE)
) chkI (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busHalf(busHalf),
  .busRdata(busRdata), .irqReq(irqReq), .irqLevel(irqLevel), .irqChan(irqChan)
);

// File: tb/pinIrqCtl_test.sv
`timescale 1ns/1ps
module pinIrqCtl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = 16'h0;
  logic        busWr = 1'b0;
  logic        busHalf = 1'b0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic [5:0]  pinIn = 6'h3F;
  logic        irqAck = 1'b0;
  logic        irqReq;
  logic [2:0]  irqLevel;
  logic [2:0]  irqChan;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pinIrqCtl uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busHalf(busHalf),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .irqAck(irqAck),
    .irqReq(irqReq), .irqLevel(irqLevel), .irqChan(irqChan)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic h, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busHalf = h; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic h, output logic [15:0] v);
    busWr = 1'b0; busAddr = a; busHalf = h;
    #1 v = busRdata;
  endtask

  task automatic checkIrq(input string tag, input logic r, input logic [2:0] l, input logic [2:0] c);
    #1 check(tag, {9'h0, irqReq, irqLevel, irqChan},
                  {9'h0, r, (r ? l : irqLevel), (r ? c : irqChan)});
  endtask

  task automatic pulseAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic testReset();
    logic [15:0] v;
    rd(16'hFCF8, 1'b1, v); check("R1 mode after reset", v, 16'h0000);
    for (int c = 0; c < 6; c++) begin
      rd(16'(16'hFC48 + 2*c), 1'b1, v); check("R1 channel pair after reset", v, 16'h0000);
    end
    checkIrq("R1 no request after reset", 1'b0, 3'd0, 3'd0);
  endtask

  task automatic testModeLayout();
    logic [15:0] v;
    wr(16'hFCF8, 1'b1, 16'hFFFF);
    rd(16'hFCF8, 1'b1, v); check("R2 upper mode bits read 0", v, 16'h0FFF);
    wr(16'hFCF8, 1'b1, 16'h0000);
    wr(16'hFCF9, 1'b0, 16'h00FF);
    rd(16'hFCF8, 1'b1, v); check("R2 high byte write lane", v, 16'h0F00);
    rd(16'hFCF9, 1'b0, v); check("R2 high byte read", v, 16'h000F);
    wr(16'hFCF8, 1'b1, 16'h0000);
  endtask

  task automatic testCtlBytes();
    logic [15:0] v;
    wr(16'hFC4A, 1'b1, 16'hFFFF);
    rd(16'hFC4A, 1'b1, v); check("R8 halfword write, R7 write 1 no set", v, 16'h7100);
    rd(16'hFC4B, 1'b0, v); check("R8 control byte read", v, 16'h0071);
    checkIrq("R9 enable without flag", 1'b0, 3'd0, 3'd0);
    wr(16'hFC4A, 1'b1, 16'h0000);
  endtask

  task automatic testEdges();
    logic [15:0] v;
    wr(16'hFCF8, 1'b1, 16'h000E);        // ch0 falling, ch1 rising
    wr(16'hFC49, 1'b0, 16'h0051);
    pinIn[0] = 1'b0;
    cyc(2);
    rd(16'hFC48, 1'b0, v); check("R3 flag not yet set at second edge", v, 16'h0000);
    cyc(1);
    rd(16'hFC48, 1'b0, v); check("R3 falling edge sets flag", v, 16'h0001);
    checkIrq("R3 request level 5 channel 0", 1'b1, 3'd5, 3'd0);
    wr(16'hFC48, 1'b0, 16'h0000);
    rd(16'hFC48, 1'b0, v); check("R7 write 0 clears flag", v, 16'h0000);
    pinIn[0] = 1'b1; cyc(4);
    rd(16'hFC48, 1'b0, v); check("R3 rising edge ignored", v, 16'h0000);

    wr(16'hFC4B, 1'b0, 16'h0031);
    pinIn[1] = 1'b0; cyc(4);
    rd(16'hFC4A, 1'b0, v); check("R4 falling edge ignored", v, 16'h0000);
    pinIn[1] = 1'b1; cyc(3);
    checkIrq("R4 rising edge request", 1'b1, 3'd3, 3'd1);
    wr(16'hFC4A, 1'b0, 16'h0000);
  endtask

  task automatic testPriority();
    logic [15:0] v;
    pinIn[1] = 1'b0; cyc(4);
    pinIn[0] = 1'b0; pinIn[1] = 1'b1; cyc(4);
    checkIrq("R10 lower level wins", 1'b1, 3'd3, 3'd1);
    wr(16'hFC4B, 1'b0, 16'h0051);
    checkIrq("R10 tie goes to lower index", 1'b1, 3'd5, 3'd0);
    wr(16'hFC49, 1'b0, 16'h0071);
    checkIrq("R9 level 7 masked", 1'b1, 3'd5, 3'd1);
    wr(16'hFC4B, 1'b0, 16'h0050);
    checkIrq("R9 no enabled unmasked channel", 1'b0, 3'd0, 3'd0);
    wr(16'hFC48, 1'b1, 16'h5000);
    wr(16'hFC4A, 1'b0, 16'h0000);
    rd(16'hFC48, 1'b1, v); check("R7 halfword clear keeps control", v, 16'h5000);
    pinIn[0] = 1'b1; cyc(4);
  endtask

  task automatic testEnableAck();
    logic [15:0] v;
    pinIn[0] = 1'b0; cyc(4);
    rd(16'hFC48, 1'b0, v); check("R9 flag latched while disabled", v, 16'h0001);
    checkIrq("R9 disabled channel silent", 1'b0, 3'd0, 3'd0);
    wr(16'hFC49, 1'b0, 16'h0051);
    checkIrq("R9 enable releases request", 1'b1, 3'd5, 3'd0);
    pulseAck();
    rd(16'hFC48, 1'b0, v); check("R11 ack clears edge channel", v, 16'h0000);
    checkIrq("R11 request gone after ack", 1'b0, 3'd0, 3'd0);
    pinIn[0] = 1'b1; cyc(4);
  endtask

  task automatic testLevelLow();
    logic [15:0] v;
    wr(16'hFC4D, 1'b0, 16'h0021);
    pinIn[2] = 1'b0; cyc(3);
    checkIrq("R5 level low request", 1'b1, 3'd2, 3'd2);
    wr(16'hFC4C, 1'b0, 16'h0000);
    rd(16'hFC4C, 1'b0, v); check("R5 clear ignored while pin low", v, 16'h0001);
    pinIn[2] = 1'b1; cyc(4);
    pulseAck();
    rd(16'hFC4C, 1'b0, v); check("R11 ack keeps level channel", v, 16'h0001);
    wr(16'hFC4C, 1'b0, 16'h0000);
    rd(16'hFC4C, 1'b0, v); check("R5 clear after pin released", v, 16'h0000);
    checkIrq("R5 request gone", 1'b0, 3'd0, 3'd0);
  endtask

  task automatic testLevelHigh();
    logic [15:0] v;
    pinIn[3] = 1'b0; cyc(4);
    wr(16'hFCF8, 1'b1, 16'h004E);        // ch3 active-high level
    wr(16'hFC4E, 1'b0, 16'h0000);
    rd(16'hFC4E, 1'b0, v); check("R6 stale flag cleared", v, 16'h0000);
    wr(16'hFC4F, 1'b0, 16'h0011);
    pinIn[3] = 1'b1; cyc(3);
    checkIrq("R6 level high request", 1'b1, 3'd1, 3'd3);
    wr(16'hFC4E, 1'b0, 16'h0000);
    rd(16'hFC4E, 1'b0, v); check("R6 clear ignored while pin high", v, 16'h0001);
    pinIn[3] = 1'b0; cyc(4);
    wr(16'hFC4E, 1'b0, 16'h0000);
    rd(16'hFC4E, 1'b0, v); check("R6 clear after pin released", v, 16'h0000);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(2);
    testReset();
    testModeLayout();
    testCtlBytes();
    testEdges();
    testPriority();
    testEnableAck();
    testLevelLow();
    testLevelHigh();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule